// File: doc/BRIEF.md
# Bus-Programmable Countdown Watchdog

This block is a watchdog timer that software reaches through a slave port on the peripheral bus (APB). A down-counter advances by one on every clock cycle in which a tick-enable input is high. A system clock divider outside the block drives that input, so the count rate follows the divider even if the divider changes in the middle of a count. When the counter lands on zero, the block raises a sticky interrupt flag. On the next tick the counter refills from the programmed reload value and keeps counting.

Software services the watchdog by writing any value to the interrupt-clear register. That write drops the flag and restarts the count at once. If software lets a second expiry happen while the flag is still set, and reset generation is enabled, the block raises a reset request that stays high until the block is reset. A key register guards all other registers against stray writes.

Top module: `apb_wdog_timer`

## Requirements
- R1: After reset, the counter and the reload register both hold all ones, control reads 0, raw status reads 0, the lock register reads 0 (unlocked), and `irq_o` and `rst_req_o` are low.
- R2: The register offsets are 0x000 reload, 0x004 counter, 0x008 control, 0x00C interrupt clear, 0x010 raw status, 0x014 masked status and 0xC00 lock. Writes to 0x004 have no effect. Reads of any other offset return 0. Every access completes with `pready` high and `pslverr` low.
- R3: While control bit 0 is 1, the counter drops by one in each cycle in which `tick_en` is high. In cycles with `tick_en` low, or while control bit 0 is 0, the counter keeps its value.
- R4: A write to the reload register stores the value and loads the counter with it in the same cycle.
- R5: A tick that brings the counter to zero sets raw status bit 0, and the counter then reads 0. The next tick loads the counter with the reload value.
- R6: A write of any data to the interrupt-clear register clears raw status and loads the counter from the reload register. If a tick arrives in the same cycle, the clear wins.
- R7: Masked status bit 0 equals raw status bit 0 AND control bit 0. `irq_o` follows masked status.
- R8: If the counter reaches zero while raw status is already set and control bit 1 is 1, `rst_req_o` goes high and stays high until reset.
- R9: Writing 0x1ACCE551 to the lock register unlocks the block, and writing any other value locks it. While locked, the lock register reads 1 and writes to the reload, control and clear registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for a write transfer |
| paddr | input | 12 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always high: no wait states |
| pslverr | output | 1 | Always low: no error response |
| tick_en | input | 1 | Count enable from the clock divider |
| irq_o | output | 1 | Masked interrupt |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
The bench builds the block with a 16-bit counter (CNT_W = 16). At that width, a full countdown from the reset value of 0xFFFF to zero takes 65535 ticks, so the bench can drive the whole range and check that the first expiry lands exactly at the end of it. The bench sweeps every reload value from 1 to 12 and checks the exact tick of each expiry and refill. It repeats one count with gaps of zero to three idle cycles between ticks, to show that only ticks advance the counter. It also checks the clear-against-tick race, the second-expiry reset, and each register's behaviour under the lock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef enum logic [2:0] {
        SEL_LOAD, SEL_VALUE, SEL_CTRL, SEL_CLR,
        SEL_RIS, SEL_MIS, SEL_LOCK, SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            12'h000: return SEL_LOAD;
            12'h004: return SEL_VALUE;
            12'h008: return SEL_CTRL;
            12'h00C: return SEL_CLR;
            12'h010: return SEL_RIS;
            12'h014: return SEL_MIS;
            12'hC00: return SEL_LOCK;
            default: return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/wdog_core.sv
module wdog_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_en,
    input  logic             rst_en,
    input  logic             ld_wr,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             ris,
    output logic             rst_req
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ris;
        logic             rst_req;
    } core_t;

    core_t s_d, s_q;
    logic [CNT_W-1:0] step_d;

    always_comb begin
        s_d    = s_q;
        step_d = (s_q.cnt == '0) ? reload_val : s_q.cnt - 1'b1;
        if (ld_wr) begin
            s_d.cnt = ld_val;
        end else if (clr_wr) begin
            s_d.cnt = reload_val;
            s_d.ris = 1'b0;
        end else if (tick_en && cnt_en) begin
            s_d.cnt = step_d;
            if (step_d == '0) begin
                if (s_q.ris && rst_en) s_d.rst_req = 1'b1;
                s_d.ris = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt     <= '1;
            s_q.ris     <= 1'b0;
            s_q.rst_req <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count   = s_q.cnt;
    assign ris     = s_q.ris;
    assign rst_req = s_q.rst_req;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_en && cnt_en) && !ld_wr && !clr_wr) |=> (count == $past(count)));
    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_en && !ld_wr && !clr_wr && count != '0) |=> (count == $past(count) - 1'b1));
    // R5
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_en && !ld_wr && !clr_wr && count == 1) |=> (ris && count == '0));
    // R6
    clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (!ris && count == $past(reload_val)));
    // R8
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    // R8
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(ris) && $past(rst_en)));
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              ris,
    output logic [DATA_W-1:0] prdata,
    output logic [CNT_W-1:0]  reload_val,
    output logic [1:0]        ctrl,
    output logic              ld_wr,
    output logic              clr_wr
);
    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [1:0]       ctrl;
        logic             locked;
    } regs_t;

    regs_t    s_d, s_q;
    reg_sel_e sel;
    logic     wr_acc;

    assign sel    = decode_addr(paddr);
    assign wr_acc = psel && penable && pwrite;
    assign ld_wr  = wr_acc && !s_q.locked && (sel == SEL_LOAD);
    assign clr_wr = wr_acc && !s_q.locked && (sel == SEL_CLR);

    always_comb begin
        s_d = s_q;
        if (ld_wr) s_d.load = pwdata[CNT_W-1:0];
        if (wr_acc && !s_q.locked && sel == SEL_CTRL) s_d.ctrl = pwdata[1:0];
        if (wr_acc && sel == SEL_LOCK) s_d.locked = (pwdata != UNLOCK_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.load   <= '1;
            s_q.ctrl   <= '0;
            s_q.locked <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        prdata = '0;
        case (sel)
            SEL_LOAD:  prdata = DATA_W'(s_q.load);
            SEL_VALUE: prdata = DATA_W'(count);
            SEL_CTRL:  prdata = DATA_W'(s_q.ctrl);
            SEL_RIS:   prdata = DATA_W'(ris);
            SEL_MIS:   prdata = DATA_W'(ris && s_q.ctrl[0]);
            SEL_LOCK:  prdata = DATA_W'(s_q.locked);
            default:   prdata = '0;
        endcase
    end

    assign reload_val = s_q.load;
    assign ctrl       = s_q.ctrl;

    // R9
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.locked && wr_acc && sel == SEL_CTRL) |=> (ctrl == $past(ctrl)));
    // R9
    locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.locked && wr_acc && sel == SEL_LOAD) |=> (reload_val == $past(reload_val)));
endmodule

// File: rtl/apb_wdog_timer.sv
module apb_wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic [CNT_W-1:0] count, reload_val;
    logic [1:0]       ctrl;
    logic             ris, ld_wr, clr_wr;

    wdog_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .count(count), .ris(ris), .prdata(prdata),
        .reload_val(reload_val), .ctrl(ctrl), .ld_wr(ld_wr), .clr_wr(clr_wr)
    );

    wdog_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cnt_en(ctrl[0]), .rst_en(ctrl[1]), .ld_wr(ld_wr), .clr_wr(clr_wr),
        .ld_val(pwdata[CNT_W-1:0]), .reload_val(reload_val),
        .count(count), .ris(ris), .rst_req(rst_req_o)
    );

    assign irq_o   = ris && ctrl[0];
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // R7
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ris && ctrl[0]));
endmodule

// File: tb/apb_wdog_timer_test.sv
module apb_wdog_timer_test;
    localparam int CW = 16;
    localparam logic [31:0] KEY = 32'h1ACC_E551;
    localparam logic [11:0] A_LOAD = 12'h000, A_VAL = 12'h004, A_CTRL = 12'h008,
                            A_CLR = 12'h00C, A_RIS = 12'h010, A_MIS = 12'h014,
                            A_LOCK = 12'hC00;

    logic clk = 1'b0, rst_n = 1'b0;
    logic psel = 0, penable = 0, pwrite = 0, tick_en = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic pready, pslverr, irq_o, rst_req_o;
    int checks = 0, errors = 0;

    apb_wdog_timer #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .tick_en(tick_en), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; tick_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, bit with_tick = 0);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        if (with_tick) tick_en = 1;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick_en = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        psel = 1; pwrite = 0; paddr = a; #1; d = prdata; psel = 0;
    endtask

    task automatic tick(int n);
        @(negedge clk); tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic rchk(string tag, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R1 reset state
        rchk("R1 value", A_VAL, 32'hFFFF);
        rchk("R1 load", A_LOAD, 32'hFFFF);
        rchk("R1 ctrl", A_CTRL, 0);
        rchk("R1 ris", A_RIS, 0);
        rchk("R1 lock", A_LOCK, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 rstreq", rst_req_o, 0);
        // R2 map, bus response, read-only value
        chk("R2 pready", pready, 1);
        chk("R2 pslverr", pslverr, 0);
        rchk("R2 unmapped", 12'h018, 0);
        rchk("R2 unmapped hi", 12'hC04, 0);
        wr(A_VAL, 32'h5);
        rchk("R2 value ro", A_VAL, 32'hFFFF);
        // R3 hold while disabled
        tick(5);
        rchk("R3 disabled hold", A_VAL, 32'hFFFF);
        // R4 + R5 sweep of reload values
        wr(A_CTRL, 1);
        for (int L = 1; L <= 12; L++) begin
            wr(A_LOAD, L);
            rchk("R4 load restarts", A_VAL, L);
            if (L > 1) tick(L - 1);
            rchk("R3 before zero", A_VAL, 1);
            rchk("R5 ris before zero", A_RIS, 0);
            tick(1);
            rchk("R5 value zero", A_VAL, 0);
            rchk("R5 ris set", A_RIS, 1);
            rchk("R7 mis set", A_MIS, 1);
            chk("R7 irq", irq_o, 1);
            tick(1);
            rchk("R5 reload", A_VAL, L);
            rchk("R5 ris sticky", A_RIS, 1);
            wr(A_CLR, 32'hDEAD);
            rchk("R6 clr ris", A_RIS, 0);
            rchk("R6 clr value", A_VAL, L);
            chk("R8 no rst", rst_req_o, 0);
        end
        // R3 tick gaps
        for (int g = 0; g <= 3; g++) begin
            wr(A_LOAD, 20);
            for (int i = 0; i < 10; i++) begin
                tick(1);
                repeat (g) @(negedge clk);
            end
            rchk("R3 gapped ticks", A_VAL, 10);
        end
        // R6 clear wins over a coincident tick
        tick(3);
        wr(A_CLR, 0, 1);
        rchk("R6 clear vs tick", A_VAL, 20);
        // R7 masked with enable off
        wr(A_LOAD, 2); tick(2);
        wr(A_CTRL, 0);
        rchk("R7 ris kept", A_RIS, 1);
        rchk("R7 mis masked", A_MIS, 0);
        chk("R7 irq masked", irq_o, 0);
        tick(4);
        rchk("R3 ctrl off hold", A_VAL, 0);
        // R8 reset request
        do_reset();
        wr(A_CTRL, 3); wr(A_LOAD, 3);
        tick(3);
        chk("R8 first expiry", rst_req_o, 0);
        tick(4);
        chk("R8 second expiry", rst_req_o, 1);
        wr(A_CLR, 0);
        chk("R8 sticky", rst_req_o, 1);
        do_reset();
        wr(A_CTRL, 1); wr(A_LOAD, 3);
        tick(7);
        chk("R8 disabled", rst_req_o, 0);
        // R9 lock
        wr(A_CLR, 0);
        wr(A_LOAD, 2); tick(2);
        wr(A_LOCK, 32'h1);
        rchk("R9 locked read", A_LOCK, 1);
        wr(A_CLR, 0);
        rchk("R9 clear ignored", A_RIS, 1);
        wr(A_LOAD, 9);
        rchk("R9 load ignored", A_LOAD, 2);
        rchk("R9 value untouched", A_VAL, 0);
        wr(A_CTRL, 0);
        rchk("R9 ctrl ignored", A_CTRL, 1);
        wr(A_LOCK, KEY);
        rchk("R9 unlocked read", A_LOCK, 0);
        wr(A_LOAD, 9);
        rchk("R9 load after unlock", A_LOAD, 9);
        // R5 full-range countdown from reset value
        do_reset();
        wr(A_CTRL, 1);
        tick(65534);
        rchk("R5 long before", A_VAL, 1);
        rchk("R5 long ris before", A_RIS, 0);
        tick(1);
        rchk("R5 long zero", A_VAL, 0);
        rchk("R5 long ris", A_RIS, 1);
        rd(A_VAL, v);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule